// File: doc/BRIEF.md
# Fixed-Point First-Order Recursive Filter

This block is a first-order IIR low-pass section in fixed-point arithmetic that computes y[n] = x[n] + a·y[n-1] once per accepted input sample. Input samples are signed 16-bit values with no integer bits (one sign bit and 15 fraction bits). The state and the output are signed 32-bit values with three integer bits (one sign bit, three integer bits and 28 fraction bits).

The feedback path keeps only the upper half of the state. It multiplies that 16-bit signed value by an unsigned 16-bit coefficient held as a parameter. The coefficient has no integer bits, so its default of 58982 stands for 0.9. Because the signed operand is multiplied by an unsigned one, the product carries no extra sign bit and lands directly in the output format. The input is brought to the same integer word-length by an arithmetic right shift of three before the addition.

A producer drives a sample with a one-cycle strobe. The new output appears on the next cycle with its own strobe. Between strobes the filter state is frozen.

Top module: `iir1_recursive`

## Requirements
- R1: A synchronous active-high reset clears the output word to zero and drops the output strobe on the following clock edge.
- R2: The feedback quantizer uses only state bits [31:16] (sign included) and drops bits [15:0]. A state whose lower half alone differs gives the same next output.
- R3: The feedback product is the quantized state, taken as signed, times the coefficient, taken as unsigned (zero-extended). The full 32-bit product is kept with its binary point at bit 28. A negative state of -4096 in the upper half gives a product of -241590272 with the default coefficient.
- R4: The input is aligned by an arithmetic right shift of 3 within 16 bits. That result forms bits [31:16] of a 32-bit addend whose bits [15:0] are zero. Starting from a zero state, input 32767 yields an output of 268369920 and input -32768 yields 0xF0000000.
- R5: The next output is the aligned input plus the feedback product, modulo 2^32, with wrap and no saturation.
- R6: The state changes only on a clock edge where the input strobe is high. With the strobe low the output word holds its value.
- R7: The output strobe is high exactly on the cycle after an accepted input. The output word already carries the new result on that cycle.
- R8: The coefficient parameter defaults to 58982, so an upper-half state of 4095 followed by a zero input gives 241531290.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| x_in | input | 16 | Signed input sample, no integer bits |
| y_out | output | 32 | Signed filter output, three integer bits |
| y_valid | output | 1 | Output strobe, one cycle after in_valid |

## Verification
Each result is due exactly one clock edge after the sample is accepted. There is one register between the input pins and both y_out and y_valid. The bench therefore drives inputs on the falling edge and compares outputs on the next falling edge after the capturing rising edge. The hold and reset checks read the outputs on that same edge, so no cycle of latency goes unexamined. The bit-exact model in the bench steps only on the cycles where it drove a strobe.

// File: rtl/iir_pkg.sv
package iir_pkg;

    // Word widths and formats
    localparam int X_W   = 16;   // input: sign + 15 fraction bits
    localparam int Y_W   = 32;   // state/output: sign + 3 int + 28 fraction
    localparam int C_W   = 16;   // coefficient: unsigned, 16 fraction bits
    localparam int Q_W   = 16;   // quantized feedback operand width
    localparam int ALIGN = 3;    // integer word-length gap between x and y

    localparam logic [C_W-1:0] COEF_DEFAULT = 16'd58982; // 0.9 in unsigned Q0.16

    typedef logic signed [X_W-1:0] samp_t;
    typedef logic signed [Y_W-1:0] acc_t;
    typedef logic signed [Q_W-1:0] qop_t;

    typedef struct packed {
        acc_t acc;
        logic vld;
    } filt_state_t;

    // Upper bits of the state, sign included
    function automatic qop_t quant_drop(input acc_t v);
        return v[Y_W-1 -: Q_W];
    endfunction

endpackage

// File: rtl/iir_quantizer.sv
module iir_quantizer
    import iir_pkg::*;
(
    input  acc_t state_i,
    output qop_t q_o
);
    // Lower half is discarded by design
    logic unused_lsb;
    assign unused_lsb = ^state_i[Y_W-Q_W-1:0];

    assign q_o = quant_drop(state_i);
endmodule

// File: rtl/iir_mixmul.sv
module iir_mixmul
    import iir_pkg::*;
#(
    parameter logic [C_W-1:0] COEF = COEF_DEFAULT
) (
    input  qop_t q_i,
    output acc_t p_o
);
    localparam int EXT_Q = Y_W - Q_W;
    localparam int EXT_C = Y_W - C_W;

    acc_t q_ext;
    acc_t c_ext;

    // Signed operand sign-extended; unsigned coefficient zero-extended
    assign q_ext = {{EXT_Q{q_i[Q_W-1]}}, q_i};
    assign c_ext = {{EXT_C{1'b0}}, COEF};
    assign p_o   = q_ext * c_ext;
endmodule

// File: rtl/iir_align.sv
module iir_align
    import iir_pkg::*;
#(
    parameter int SHIFT = ALIGN
) (
    input  samp_t x_i,
    output acc_t  a_o
);
    localparam int PAD = Y_W - X_W;

    samp_t shifted;

    generate
        if (SHIFT == 0) begin : g_noshift
            assign shifted = x_i;
        end else begin : g_shift
            assign shifted = x_i >>> SHIFT;
        end
    endgenerate

    // Place in the upper half so the binary point lines up with y
    assign a_o = {shifted, {PAD{1'b0}}};
endmodule

// File: rtl/iir1_recursive.sv
module iir1_recursive
    import iir_pkg::*;
#(
    parameter logic [C_W-1:0] COEF = COEF_DEFAULT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic signed [X_W-1:0] x_in,
    output logic signed [Y_W-1:0] y_out,
    output logic                  y_valid
);
    filt_state_t st_q;
    filt_state_t st_d;

    qop_t q_fb;
    acc_t prod;
    acc_t x_al;
    acc_t sum;

    iir_quantizer u_quant (
        .state_i (st_q.acc),
        .q_o     (q_fb)
    );

    iir_mixmul #(.COEF(COEF)) u_mul (
        .q_i (q_fb),
        .p_o (prod)
    );

    iir_align #(.SHIFT(ALIGN)) u_align (
        .x_i (x_in),
        .a_o (x_al)
    );

    // Modular sum: wraps on overflow
    assign sum = x_al + prod;

    always_comb begin
        st_d.vld = in_valid;
        st_d.acc = in_valid ? sum : st_q.acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_out   = st_q.acc;
    assign y_valid = st_q.vld;
endmodule

// File: rtl/iir1_recursive_chk.sv
module iir1_recursive_chk
    import iir_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic signed [X_W-1:0] x_in,
    input logic signed [Y_W-1:0] y_out,
    input logic                  y_valid
);
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (y_out == '0 && !y_valid));

    // R7
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> y_valid);

    // R7
    strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !y_valid);

    // R6
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(y_out));

    // R4
    align_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && y_out == '0) |=>
            (y_out[15:0] == 16'h0 && $signed(y_out[31:16]) == ($past(x_in) >>> ALIGN)));
endmodule

bind iir1_recursive iir1_recursive_chk i_chk (.*);

// File: tb/test_iir1_recursive.sv
module test_iir1_recursive;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] COEF = 16'd58982;

    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid;
    logic signed [15:0] x_in;
    logic signed [31:0] y_out;
    logic               y_valid;

    int checks = 0;
    int fails  = 0;
    logic signed [31:0] model_y;

    iir1_recursive i_iir1_recursive (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .x_in     (x_in),
        .y_out    (y_out),
        .y_valid  (y_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bit-exact reference: quantize, mixed multiply, align, add with wrap
    function automatic logic signed [31:0] ref_next(input logic signed [31:0] y,
                                                    input logic signed [15:0] x);
        logic signed [15:0] q;
        logic signed [31:0] p;
        logic signed [15:0] xs;
        logic signed [31:0] al;
        q  = y[31:16];
        p  = 32'($signed({{16{q[15]}}, q}) * $signed({16'b0, COEF}));
        xs = x >>> 3;
        al = {xs, 16'h0};
        return al + p;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d (0x%08h) expected=%0d (0x%08h)",
                     req, $signed(act), act, $signed(exp), exp);
        end
    endtask

    // Drive one cycle; compare outputs after the capturing edge
    task automatic step(input logic v, input logic signed [15:0] x, input string req);
        in_valid = v;
        x_in     = x;
        @(posedge clk);
        @(negedge clk);
        if (v) model_y = ref_next(model_y, x);
        check({req, " R7 strobe"}, {31'b0, y_valid}, {31'b0, v});
        check(req, y_out, model_y);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0; x_in = '0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_y = '0;
        check("R1 y", y_out, 32'h0);
        check("R1 strobe", {31'b0, y_valid}, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; in_valid = 1'b0; x_in = '0;
        @(negedge clk);
        do_reset();

        // Impulse: R4 alignment, then R8 coefficient value
        step(1'b1, 16'sd32767, "R4 impulse");
        check("R4 literal", y_out, 32'd268369920);
        step(1'b1, 16'sd0, "R8 decay");
        check("R8 literal", y_out, 32'd241531290);
        for (int i = 0; i < 20; i++) step(1'b1, 16'sd0, "R5 impulse tail");

        // Negative full scale from zero: R4 and R3 sign handling
        do_reset();
        step(1'b1, -16'sd32768, "R4 negfs");
        check("R4 negfs literal", y_out, 32'hF0000000);
        step(1'b1, 16'sd0, "R3 neg product");
        check("R3 literal", y_out, -32'sd241590272);
        for (int i = 0; i < 60; i++) step(1'b1, -16'sd32768, "R5 negfs wrap");

        // Step input with gaps: R6 hold
        do_reset();
        for (int i = 0; i < 60; i++) begin
            step(1'b1, 16'sd16384, "R5 step");
            if (i % 7 == 3) step(1'b0, 16'sd12345, "R6 hold");
        end

        // R2: lower half of state must not matter
        do_reset();
        step(1'b1, 16'sd7, "R2 small x");      // state lower half zero (x>>>3 = 0)
        check("R2 small literal", y_out, 32'h0);
        step(1'b1, 16'sd8, "R2 seed");
        step(1'b1, 16'sd0, "R2 drop");
        check("R2 literal", y_out, 32'd58982);

        // Constrained random with random strobe and mid-run reset
        for (int i = 0; i < 400; i++) begin
            logic v;
            logic signed [15:0] x;
            v = ($urandom % 4) != 0;
            case ($urandom % 4)
                0: x = 16'sh7FFF;
                1: x = 16'sh8000;
                default: x = 16'($urandom);
            endcase
            step(v, x, "R5 random");
            if (i == 200) do_reset();
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule